// File: doc/BRIEF.md
# Two-Level Round-Robin Bus Arbiter

This block chooses which master may drive a shared parallel bus. Four requesters are always present. Up to three more can be switched on through enable inputs. Each requester raises a request line and receives a grant line. A configuration bit for each requester places it in a high or a low priority level. The high level rotates round-robin over its members plus one extra slot that stands for the whole low level. Each time that slot wins, the low level's own round-robin pointer picks exactly one low requester. This stops either level from starving the other.

A master that holds the grant keeps it for as long as its request stays high. The next winner is chosen only in the cycle in which the holder's request drops. When nothing is requesting, the bus is parked according to a mode input. Mode 0 parks on the last master that won arbitration. Mode 1 parks on a fixed index. Modes 2 and 3 leave the bus with no grant. All configuration arrives as plain inputs.

Top module: `prio_bus_arb`

## Requirements
- R1: At most one bit of gnt_o is high in any cycle, and bit i grants requester i.
- R2: While the granted requester keeps its request high and stays enabled, gnt_o does not change, even if other requests appear.
- R3: Requester i is high priority when hi_prio_i[i]=1. The high rotation has positions 0..N_REQ-1 for the high requesters and position N_REQ for the low level. The search starts at the high pointer, and afterwards the pointer moves to the winner's position plus one, wrapping to 0.
- R4: When the low-level position wins, one low requester is chosen by searching from the low pointer. The low pointer then moves to that requester plus one, wrapping modulo N_REQ.
- R5: Requester N_FIXED+k is enabled only while opt_en_i[k]=1. A disabled requester is skipped without using up a turn, and it is never granted.
- R6: With park_mode_i=0 and no enabled request, the grant goes to the last requester that won arbitration. This is requester 0 after reset.
- R7: With park_mode_i=1 and no enabled request, the grant goes to park_idx_i. There is no grant if that index is N_REQ or above, or if the requester it names is disabled.
- R8: With park_mode_i of 2 or 3 and no enabled request, no grant is given.
- R9: While rst_ni is low, gnt_o is 0, and both round-robin pointers reset to 0.
- R10: hi_prio_i is used only at an arbitration decision, so changing it does not move a grant that is being held.
- R11: A decision is registered: the inputs sampled at a rising edge determine gnt_o right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_REQ | Request line for each requester |
| opt_en_i | input | N_OPT | Enable for each optional requester |
| hi_prio_i | input | N_REQ | 1 places the requester in the high level |
| park_mode_i | input | 2 | Parking policy: 0 last winner, 1 fixed index, 2 or 3 none |
| park_idx_i | input | $clog2(N_REQ) | Fixed parking index for mode 1 |
| gnt_o | output | N_REQ | Grant line for each requester |

## Verification
The bench builds the block with its default values, N_FIXED=4 and N_OPT=3. This gives seven requesters and an eight-position high rotation, with the low-level slot at the last position. With these values the vectors can reach a high pointer that wraps from the low slot back to 0, a low pointer that wraps past requester 6, and a disabled optional requester being skipped or refused as a parking target. Index 7 can also be applied as a parking index, which lies outside the requester range.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    PARK_LAST  = 2'd0,
    PARK_FIXED = 2'd1,
    PARK_NONE  = 2'd2,
    PARK_NONE3 = 2'd3
  } park_mode_e;
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int W  = 8,
  parameter int PW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  input  logic [PW-1:0] ptr_i,
  output logic          found_o,
  output logic [PW-1:0] idx_o
);
  int j;
  // scan from highest offset down so the nearest match to ptr_i wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    j       = 0;
    for (int i = W - 1; i >= 0; i--) begin
      j = int'(ptr_i) + i;
      if (j >= W) j = j - W;
      if (vec_i[j]) begin
        found_o = 1'b1;
        idx_o   = PW'(j);
      end
    end
  end
endmodule

// File: rtl/park_sel.sv
module park_sel #(
  parameter int N_REQ = 7,
  parameter int IW    = $clog2(N_REQ)
) (
  input  arb_pkg::park_mode_e mode_i,
  input  logic [IW-1:0]       last_i,
  input  logic [IW-1:0]       fix_i,
  input  logic [N_REQ-1:0]    en_i,
  output logic                vld_o,
  output logic [IW-1:0]       idx_o
);
  import arb_pkg::*;
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    unique case (mode_i)
      PARK_LAST: begin
        idx_o = last_i;
        vld_o = en_i[last_i];
      end
      PARK_FIXED: begin
        idx_o = fix_i;
        vld_o = (int'(fix_i) < N_REQ) && en_i[fix_i];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/prio_bus_arb.sv
module prio_bus_arb #(
  parameter int N_FIXED = 4,
  parameter int N_OPT   = 3,
  localparam int N_REQ  = N_FIXED + N_OPT,
  localparam int IW     = $clog2(N_REQ),
  localparam int HW     = $clog2(N_REQ + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_REQ-1:0] req_i,
  input  logic [N_OPT-1:0] opt_en_i,
  input  logic [N_REQ-1:0] hi_prio_i,
  input  logic [1:0]       park_mode_i,
  input  logic [IW-1:0]    park_idx_i,
  output logic [N_REQ-1:0] gnt_o
);
  import arb_pkg::*;

  logic [N_REQ-1:0] en_mask, eff_req;
  logic [N_REQ:0]   hi_vec;
  logic             hi_found, lo_found, use_lo, hold;
  logic [HW-1:0]    hi_win, hp_q, hp_d;
  logic [IW-1:0]    lo_win, lp_q, lp_d;
  logic [IW-1:0]    own_q, own_d, last_q, last_d, pk_idx;
  logic             vld_q, vld_d, pk_vld;

  assign en_mask = {opt_en_i, {N_FIXED{1'b1}}};
  assign eff_req = req_i & en_mask;
  assign hi_vec  = {|(eff_req & ~hi_prio_i), eff_req & hi_prio_i};
  assign hold    = vld_q && eff_req[own_q];

  rr_pick #(.W(N_REQ + 1), .PW(HW)) u_hi (
    .vec_i(hi_vec), .ptr_i(hp_q), .found_o(hi_found), .idx_o(hi_win)
  );

  rr_pick #(.W(N_REQ), .PW(IW)) u_lo (
    .vec_i(eff_req & ~hi_prio_i), .ptr_i(lp_q), .found_o(lo_found), .idx_o(lo_win)
  );

  park_sel #(.N_REQ(N_REQ), .IW(IW)) u_park (
    .mode_i(park_mode_e'(park_mode_i)), .last_i(last_q), .fix_i(park_idx_i),
    .en_i(en_mask), .vld_o(pk_vld), .idx_o(pk_idx)
  );

  assign use_lo = (hi_win == HW'(N_REQ)) && lo_found;

  always_comb begin
    own_d  = own_q;
    vld_d  = vld_q;
    hp_d   = hp_q;
    lp_d   = lp_q;
    last_d = last_q;
    if (!hold) begin
      if (hi_found) begin
        vld_d = 1'b1;
        hp_d  = (hi_win == HW'(N_REQ)) ? '0 : hi_win + 1'b1;
        if (use_lo) begin
          own_d = lo_win;
          lp_d  = (lo_win == IW'(N_REQ - 1)) ? '0 : lo_win + 1'b1;
        end else begin
          own_d = IW'(hi_win);
        end
        last_d = own_d;
      end else begin
        vld_d = pk_vld;
        own_d = pk_idx;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q  <= '0;
      vld_q  <= 1'b0;
      hp_q   <= '0;
      lp_q   <= '0;
      last_q <= '0;
    end else begin
      own_q  <= own_d;
      vld_q  <= vld_d;
      hp_q   <= hp_d;
      lp_q   <= lp_d;
      last_q <= last_d;
    end
  end

  for (genvar g = 0; g < N_REQ; g++) begin : g_gnt
    assign gnt_o[g] = vld_q && (own_q == IW'(g));
  end
endmodule

// File: rtl/prio_bus_arb_chk.sv
module prio_bus_arb_chk #(
  parameter int N_FIXED = 4,
  parameter int N_OPT   = 3,
  localparam int N_REQ  = N_FIXED + N_OPT
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_REQ-1:0] req_i,
  input logic [N_OPT-1:0] opt_en_i,
  input logic [1:0]       park_mode_i,
  input logic [N_REQ-1:0] gnt_o
);
  logic [N_REQ-1:0] eff;
  assign eff = req_i & {opt_en_i, {N_FIXED{1'b1}}};

  // R1
  one_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  // R2
  hold_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(gnt_o & eff)) |=> $stable(gnt_o));

  // R3
  serve_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(|(gnt_o & eff)) && (|eff)) |=> (|(gnt_o & $past(eff))));

  // R8
  park_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(|eff) && park_mode_i[1]) |=> (gnt_o == '0));

  for (genvar k = 0; k < N_OPT; k++) begin : g_opt
    // R5
    opt_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gnt_o[N_FIXED + k] |-> $past(opt_en_i[k]));
  end
endmodule

bind prio_bus_arb prio_bus_arb_chk #(.N_FIXED(N_FIXED), .N_OPT(N_OPT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .opt_en_i(opt_en_i),
  .park_mode_i(park_mode_i), .gnt_o(gnt_o)
);

// File: tb/sim_prio_bus_arb.sv
module sim_prio_bus_arb;
  localparam int NR = 7;
  localparam int NV = 20;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NR-1:0] req_i = '0;
  logic [2:0]    opt_en_i = 3'b111;
  logic [NR-1:0] hi_prio_i = '1;
  logic [1:0]    park_mode_i = 2'd0;
  logic [2:0]    park_idx_i = '0;
  logic [NR-1:0] gnt_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk_i = ~clk_i;

  prio_bus_arb u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .opt_en_i(opt_en_i),
    .hi_prio_i(hi_prio_i), .park_mode_i(park_mode_i), .park_idx_i(park_idx_i),
    .gnt_o(gnt_o)
  );

  // {tag, req, opt_en, hi_prio, park_mode, park_idx, expected gnt}
  localparam logic [32:0] VECS [NV] = '{
    {4'd6,  7'b0000000, 3'b111, 7'b1111111, 2'd0, 3'd0, 7'b0000001}, // R6 park on 0 after reset
    {4'd3,  7'b0000110, 3'b111, 7'b1111111, 2'd0, 3'd0, 7'b0000010}, // R3 search from 0
    {4'd2,  7'b0000110, 3'b111, 7'b1111111, 2'd0, 3'd0, 7'b0000010}, // R2 held
    {4'd3,  7'b0000100, 3'b111, 7'b1111111, 2'd0, 3'd0, 7'b0000100}, // R3
    {4'd3,  7'b0000011, 3'b111, 7'b1111111, 2'd0, 3'd0, 7'b0000001}, // R3 wrap past low slot
    {4'd11, 7'b0000010, 3'b111, 7'b1111111, 2'd0, 3'd0, 7'b0000010}, // R11
    {4'd3,  7'b1000000, 3'b111, 7'b1111111, 2'd0, 3'd0, 7'b1000000}, // R3
    {4'd5,  7'b1000001, 3'b011, 7'b1111111, 2'd0, 3'd0, 7'b0000001}, // R5 skip disabled 6
    {4'd6,  7'b1000000, 3'b011, 7'b1111111, 2'd0, 3'd0, 7'b0000001}, // R6 park last
    {4'd7,  7'b0000000, 3'b111, 7'b1111111, 2'd1, 3'd5, 7'b0100000}, // R7 fixed 5
    {4'd7,  7'b0000000, 3'b101, 7'b1111111, 2'd1, 3'd5, 7'b0000000}, // R7 fixed but disabled
    {4'd8,  7'b0000000, 3'b111, 7'b1111111, 2'd2, 3'd0, 7'b0000000}, // R8
    {4'd4,  7'b0001101, 3'b111, 7'b0000011, 2'd0, 3'd0, 7'b0000100}, // R4 low slot, lo ptr 0
    {4'd3,  7'b0001001, 3'b111, 7'b0000011, 2'd0, 3'd0, 7'b0000001}, // R3 high after low slot
    {4'd4,  7'b0001000, 3'b111, 7'b0000011, 2'd0, 3'd0, 7'b0001000}, // R4 lo ptr 3
    {4'd3,  7'b1000101, 3'b111, 7'b0000011, 2'd0, 3'd0, 7'b0000001}, // R3
    {4'd4,  7'b1000100, 3'b111, 7'b0000011, 2'd0, 3'd0, 7'b1000000}, // R4 lo ptr 4 -> 6
    {4'd4,  7'b0000100, 3'b111, 7'b0000011, 2'd0, 3'd0, 7'b0000100}, // R4 lo ptr wrapped
    {4'd10, 7'b0000100, 3'b111, 7'b0000100, 2'd0, 3'd0, 7'b0000100}, // R10 prio change held
    {4'd1,  7'b0000011, 3'b111, 7'b0000001, 2'd0, 3'd0, 7'b0000001}  // R1 high beats low
  };

  task automatic check(input int tag, input logic [NR-1:0] exp);
    n_chk++;
    if (gnt_o !== exp) begin
      n_bad++;
      $display("FAIL R%0d gnt_o=%b expected=%b", tag, gnt_o, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 check(9, '0); // R9 grant low in reset
    @(negedge clk_i) rst_ni = 1'b1;
    for (int v = 0; v < NV; v++) begin
      {req_i, opt_en_i, hi_prio_i, park_mode_i, park_idx_i} = VECS[v][28:7];
      @(posedge clk_i);
      #1 check(int'(VECS[v][32:29]), VECS[v][6:0]);
      @(negedge clk_i);
    end
    // R7: index beyond requester range parks nowhere
    req_i = '0; opt_en_i = 3'b111; park_mode_i = 2'd1; park_idx_i = 3'd7;
    @(posedge clk_i);
    #1 check(7, '0);
    // R8: mode 3 behaves as no parking
    @(negedge clk_i) park_mode_i = 2'd3;
    @(posedge clk_i);
    #1 check(8, '0);
    // R9: asynchronous reset drops a live grant at once
    @(negedge clk_i) begin park_mode_i = 2'd0; req_i = 7'b0001000; hi_prio_i = '1; end
    @(posedge clk_i);
    #1 check(3, 7'b0001000);
    rst_ni = 1'b0;
    #1 check(9, '0);
    @(negedge clk_i) begin rst_ni = 1'b1; req_i = '0; end
    @(posedge clk_i);
    #1 check(6, 7'b0000001); // R6 last winner reset to 0
    // R9: pointers back at 0 after reset
    @(negedge clk_i) req_i = 7'b0100010;
    @(posedge clk_i);
    #1 check(9, 7'b0000010);
    @(negedge clk_i);
    finish_run();
  end
endmodule